// File: doc/BRIEF.md
# Converter Event Flag and Interrupt Mask Block

This block keeps sticky status flags for five interrupt causes of a data converter with a DMA path: data ready, buffer half full, buffer full, gain saturation and overflow. A one-cycle pulse on an event input latches the matching flag. The flag then stays set until software writes a one to its bit position. Writing a zero leaves the flag unchanged.

A second register holds a per-bit enable mask. The single interrupt output is high whenever any flag that is set also has its enable bit set. The raw flags can always be read. Software can therefore leave the mask at zero and poll the flags instead of taking interrupts.

Access is through a small register bus. It has a write strobe, a one-bit address, write data and combinational read data. Address 0 selects the flags and address 1 selects the mask.

Top module: `cvt_irq_flags`

## Requirements
- R1: While reset is asserted and after it is released, the flags, the mask and `irq_o` are all zero.
- R2: A high on `evt_i[k]` in a cycle sets flag bit k at the next clock edge. The flag stays set until it is cleared. The bit map is: 0 data ready, 1 buffer half full, 2 buffer full, 3 gain saturation, 4 overflow.
- R3: A bus write to address 0 clears every flag whose `bus_wdata` bit is 1.
- R4: A bus write to address 0 leaves every flag whose `bus_wdata` bit is 0 unchanged.
- R5: If an event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R6: A bus write to address 1 loads `bus_wdata[4:0]` into the mask. Writes to address 0 do not change the mask, and writes to address 1 do not change the flags.
- R7: `irq_o` is a register output. It is high exactly when (flags AND mask) is nonzero, and it changes on the same clock edge as the flags or mask that cause the change.
- R8: With the mask at zero, `irq_o` stays low, while events still set flags that read back at address 0.
- R9: `bus_rdata` returns the flags at address 0 and the mask at address 1. Bits 7:5 always read zero, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | Event pulses, one per flag |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 flags, 1 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench fires an event into a bit in the same cycle that software clears that bit. A design that lets the clear win would silently drop the event. It also writes zeros over set flags, which catches a design that treats writes as plain loads and wipes pending flags. Long random runs mix mask patterns, mask-zero polling and writes with the upper bits set. These expose an interrupt that lags the flags by a cycle, fires while masked, or leaks into the unused read bits.

// File: rtl/cvt_irq_flags.sv
module cvt_irq_flags #(
  parameter int DATA_W = 8,
  parameter int N_EVT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - N_EVT;

  logic [N_EVT-1:0] flag_q, mask_q, flag_d, mask_d, clr;

  assign clr    = (bus_wr && !bus_addr) ? bus_wdata[N_EVT-1:0] : '0;
  assign flag_d = (flag_q & ~clr) | evt_i;
  assign mask_d = (bus_wr && bus_addr) ? bus_wdata[N_EVT-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      irq_o  <= |(flag_d & mask_d);
    end
  end

  assign bus_rdata = {{PAD_W{1'b0}}, (bus_addr ? mask_q : flag_q)};
endmodule

// File: rtl/cvt_irq_flags_chk.sv
module cvt_irq_flags_chk #(
  parameter int DATA_W = 8,
  parameter int N_EVT  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EVT-1:0]  evt_i,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_EVT-1:0]  flag_q,
  input logic [N_EVT-1:0]  mask_q,
  input logic              irq_o
);
  logic [N_EVT-1:0] wr_ones;
  assign wr_ones = (bus_wr && !bus_addr) ? bus_wdata[N_EVT-1:0] : '0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (flag_q == '0 && mask_q == '0 && !irq_o));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> ((flag_q & $past(bus_wdata[N_EVT-1:0] & ~evt_i)) == '0));

  assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(wr_ones)) == '0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> (mask_q == $past(bus_wdata[N_EVT-1:0])));

  assert_irq_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(flag_q & mask_q));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

bind cvt_irq_flags cvt_irq_flags_chk #(.DATA_W(DATA_W), .N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .flag_q(flag_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/cvt_irq_flags_tb.sv
module cvt_irq_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_i = '0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [4:0] m_flags = '0, m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [4:0] exp_flags(logic [4:0] f, logic [4:0] e, logic w, logic a, logic [7:0] d);
    logic [4:0] c;
    c = (w && !a) ? d[4:0] : 5'd0;
    return (f & ~c) | e;
  endfunction

  function automatic logic [4:0] exp_mask(logic [4:0] m, logic w, logic a, logic [7:0] d);
    return (w && a) ? d[4:0] : m;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [4:0] e, logic w, logic a, logic [7:0] d);
    @(negedge clk);
    evt_i = e; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    m_flags = exp_flags(m_flags, e, w, a, d);
    m_mask  = exp_mask(m_mask, w, a, d);
    #1;
    check("R7 irq", {7'd0, irq_o}, {7'd0, |(m_flags & m_mask)});
    check("R2/R6/R9 rdata", bus_rdata, {3'd0, a ? m_mask : m_flags});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", {7'd0, irq_o}, 8'd0);
    check("R1 flags in reset", bus_rdata, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 1, 0);
    check("R1 mask after reset", bus_rdata, 8'd0);

    // R8: events with mask zero, polled
    cyc(5'b10101, 0, 0, 0);
    check("R8 flags polled", bus_rdata, 8'h15);
    check("R8 irq quiet", {7'd0, irq_o}, 8'd0);
    // R4: write zeros
    cyc(0, 1, 0, 8'h00);
    check("R4 zero write keeps", bus_rdata, 8'h15);
    // R3: clear bit 0 and 4
    cyc(0, 1, 0, 8'h11);
    check("R3 w1c", bus_rdata, 8'h04);
    // R5: set and clear same bit
    cyc(5'b00010, 1, 0, 8'h02);
    check("R5 set wins", bus_rdata, 8'h06);
    // R9: upper bits
    cyc(0, 1, 1, 8'hE8);
    check("R9 mask upper zero", bus_rdata, 8'h08);
    cyc(5'b01000, 0, 0, 0);
    check("R7 irq from sat", {7'd0, irq_o}, 8'd1);
    cyc(0, 1, 0, 8'hE0);
    check("R9 upper write no effect", bus_rdata, 8'h0E);
    cyc(0, 1, 0, 8'h08);
    check("R7 irq drops on clear", {7'd0, irq_o}, 8'd0);
    check("R6 mask untouched by flag write", {3'd0, m_mask}, 8'h08);
    cyc(0, 0, 1, 0);
    check("R6 mask readback", bus_rdata, 8'h08);

    for (int i = 0; i < 4000; i++) begin
      logic [4:0] e;
      e = 5'd0;
      for (int b = 0; b < 5; b++) e[b] = ($urandom % 6) == 0;
      if (i % 500 < 60) e = 5'd0;
      cyc(e, ($urandom % 3) == 0, $urandom % 2, 8'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule